// File: doc/BRIEF.md
# Interrupt Group Register Bank

This block holds the register state of one interrupt source group. Up to 32 event lines arrive as single-cycle pulses or levels. Each line that is not masked sets a sticky bit in the identity register. Software clears those bits by writing ones to them. A separate enable register decides which latched bits count toward a single group-pending level. That level feeds an upstream aggregator that combines several groups.

The block sits on a simple register bus. One request with address, write flag and write data may be issued in a cycle. A read returns its data one cycle later, flagged by a response valid. Only full, word-aligned 32-bit accesses are decoded.

Masking is applied before latching. An event that arrives while its mask bit is set is lost, and clearing the mask later does not bring it back. The enable register only gates the pending output; it never stops an event from being latched.

Top module: `irq_group_regs`

## Requirements
- R1: After reset the mask, identity and enable registers read as 0 and the pending output is low.
- R2: An event bit that is high in a cycle while its mask bit is 0 sets the matching identity bit. The bit stays set after the event line drops.
- R3: An event bit that is high while its mask bit is 1 leaves the identity bit unchanged, and clearing the mask afterwards does not set it. The mask value in effect is the one held before that cycle.
- R4: Writing the identity register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: Writing the mask or enable register replaces its whole value with the write data, which reads back unchanged.
- R6: The pending output is high exactly when some bit is set in both the identity and the enable register. It reflects a register write from the cycle after that write, and enable never stops latching.
- R7: When an unmasked event and a clearing write hit the same identity bit in the same cycle, the bit ends up set.
- R8: The status register is read-only. A read returns the raw event inputs of the request cycle, and a write to it changes no register.
- R9: A read request gives response valid with data exactly one cycle later. A write request gives no response.
- R10: The register is picked by address bits [3:2]: 0 is status (0x0), 1 is mask (0x4), 2 is identity (0x8) and 3 is enable (0xC). Requests with address bits [1:0] nonzero, or with bits above 3 nonzero, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_SRC (32) | Raw event lines, high = event present |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Byte offset from the group base |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | DATA_W (32) | Read data |
| pend_o | output | 1 | Group pending level to the upstream aggregator |

## Verification
The hardest case to reach from the ports is a collision between an event and a clearing write on the same identity bit. The bench drives the event line and the identity write in the same cycle and then reads the bit back. The loss of masked events is also subtle, since it only shows once the mask is later removed. The bench pulses an event under mask, clears the mask, and reads the identity register to confirm the bit never appears. Enable gating is exercised by latching bits with enable at zero and then turning single enable bits on and off while watching the pending output.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

   typedef enum logic [1:0] {
      REG_STAT  = 2'd0,
      REG_MASK  = 2'd1,
      REG_IDENT = 2'd2,
      REG_ENAB  = 2'd3
   } irqg_reg_e;

   localparam int REG_COUNT = 4;
   localparam int SEL_LSB   = 2;

   function automatic irqg_reg_e sel_to_reg(input logic [1:0] sel);
      return irqg_reg_e'(sel);
   endfunction

endpackage

// File: rtl/irqg_decode.sv
module irqg_decode #(
   parameter int ADDR_W = 4
) (
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [ADDR_W-1:0]      req_addr,
   output logic [irqg_pkg::REG_COUNT-1:0] wr_hit,
   output logic                   rd_go,
   output irqg_pkg::irqg_reg_e    rd_sel
);
   import irqg_pkg::*;

   localparam int SEL_MSB = SEL_LSB + 1;

   logic upper_ok;
   logic aligned;
   logic hit;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("irqg_decode: ADDR_W must be at least 4");
   end

   generate
      if (ADDR_W > 4) begin : g_upper
         assign upper_ok = (req_addr[ADDR_W-1:4] == '0);
      end else begin : g_no_upper
         assign upper_ok = 1'b1;
      end
   endgenerate

   assign aligned = (req_addr[1:0] == 2'b00);
   assign hit     = req_valid & aligned & upper_ok;
   assign rd_go   = hit & ~req_write;
   assign rd_sel  = sel_to_reg(req_addr[SEL_MSB:SEL_LSB]);

   for (genvar r = 0; r < REG_COUNT; r++) begin : g_wr
      assign wr_hit[r] = hit & req_write & (req_addr[SEL_MSB:SEL_LSB] == 2'(r));
   end

endmodule

// File: rtl/irqg_wreg.sv
module irqg_wreg #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/irqg_ident.sv
module irqg_ident #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic [NUM_SRC-1:0] mask,
   input  logic               clr_we,
   input  logic [NUM_SRC-1:0] clr_data,
   output logic [NUM_SRC-1:0] iir
);
   for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      logic set_b;
      logic clr_b;
      assign set_b = evt[b] & ~mask[b];
      assign clr_b = clr_we & clr_data[b];
      always_ff @(posedge clk) begin
         if (!rst_n)     iir[b] <= 1'b0;
         else if (set_b) iir[b] <= 1'b1;
         else if (clr_b) iir[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/irqg_rdport.sv
module irqg_rdport #(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_go,
   input  irqg_pkg::irqg_reg_e rd_sel,
   input  logic [NUM_SRC-1:0]  stat_v,
   input  logic [NUM_SRC-1:0]  mask_v,
   input  logic [NUM_SRC-1:0]  ident_v,
   input  logic [NUM_SRC-1:0]  enab_v,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata
);
   import irqg_pkg::*;

   logic [NUM_SRC-1:0] pick;
   logic [DATA_W-1:0]  pick_w;

   always_comb begin
      case (rd_sel)
         REG_STAT:  pick = stat_v;
         REG_MASK:  pick = mask_v;
         REG_IDENT: pick = ident_v;
         default:   pick = enab_v;
      endcase
   end

   generate
      if (NUM_SRC < DATA_W) begin : g_pad
         assign pick_w = {{(DATA_W-NUM_SRC){1'b0}}, pick};
      end else begin : g_full
         assign pick_w = pick;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_go;
         if (rd_go) rsp_rdata <= pick_w;
      end
   end
endmodule

// File: rtl/irq_group_regs.sv
module irq_group_regs #(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic               pend_o
);
   import irqg_pkg::*;

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("irq_group_regs: NUM_SRC must be in 1..DATA_W");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("irq_group_regs: only 32-bit accesses are supported");
   end

   logic [REG_COUNT-1:0] wr_hit;
   logic                 rd_go;
   irqg_reg_e            rd_sel;
   logic [NUM_SRC-1:0]   wdata_n;
   logic [NUM_SRC-1:0]   mask_q;
   logic [NUM_SRC-1:0]   ier_q;
   logic [NUM_SRC-1:0]   iir_q;

   assign wdata_n = req_wdata[NUM_SRC-1:0];

   irqg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .wr_hit    (wr_hit),
      .rd_go     (rd_go),
      .rd_sel    (rd_sel)
   );

   irqg_wreg #(.WIDTH(NUM_SRC)) u_mask (
      .clk (clk), .rst_n (rst_n),
      .we  (wr_hit[REG_MASK]), .d (wdata_n), .q (mask_q)
   );

   irqg_wreg #(.WIDTH(NUM_SRC)) u_enab (
      .clk (clk), .rst_n (rst_n),
      .we  (wr_hit[REG_ENAB]), .d (wdata_n), .q (ier_q)
   );

   irqg_ident #(.NUM_SRC(NUM_SRC)) u_ident (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_i),
      .mask     (mask_q),
      .clr_we   (wr_hit[REG_IDENT]),
      .clr_data (wdata_n),
      .iir      (iir_q)
   );

   irqg_rdport #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_go     (rd_go),
      .rd_sel    (rd_sel),
      .stat_v    (evt_i),
      .mask_v    (mask_q),
      .ident_v   (iir_q),
      .enab_v    (ier_q),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   assign pend_o = |(iir_q & ier_q);

endmodule

// File: rtl/irqg_chk.sv
module irqg_chk #(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] evt_i,
   input logic               req_valid,
   input logic               req_write,
   input logic [ADDR_W-1:0]  req_addr,
   input logic [DATA_W-1:0]  req_wdata,
   input logic               rsp_valid,
   input logic               pend_o,
   input logic [NUM_SRC-1:0] mask_q,
   input logic [NUM_SRC-1:0] iir_q,
   input logic [NUM_SRC-1:0] ier_q
);
   logic               rd_req;
   logic               wr_ident;
   logic               wr_mask;
   logic [NUM_SRC-1:0] live;

   assign rd_req   = req_valid && !req_write && (req_addr[1:0] == 2'b00)
                     && ((req_addr >> 4) == '0);
   assign wr_ident = req_valid && req_write && (req_addr == ADDR_W'(8));
   assign wr_mask  = req_valid && req_write && (req_addr == ADDR_W'(4));
   assign live     = evt_i & ~mask_q;

   // R9
   rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rsp_valid);
   // R9
   no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rsp_valid);
   // R7
   evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live != '0) |=> ((iir_q & $past(live)) == $past(live)));
   // R3
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_q & ~$past(iir_q) & ~$past(live)) == '0);
   // R4
   clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(iir_q) & ~iir_q) != '0) |-> $past(wr_ident));
   // R5
   mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> (mask_q == $past(req_wdata[NUM_SRC-1:0])));
   // R6
   pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_q == '0 || iir_q == '0) |-> !pend_o);

endmodule

bind irq_group_regs irqg_chk #(
   .NUM_SRC (NUM_SRC),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_i     (evt_i),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .rsp_valid (rsp_valid),
   .pend_o    (pend_o),
   .mask_q    (mask_q),
   .iir_q     (iir_q),
   .ier_q     (ier_q)
);

// File: tb/irq_group_regs_bench.sv
module irq_group_regs_bench;
   localparam logic [3:0] A_STAT  = 4'h0;
   localparam logic [3:0] A_MASK  = 4'h4;
   localparam logic [3:0] A_IDENT = 4'h8;
   localparam logic [3:0] A_ENAB  = 4'hC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt_i = '0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        pend_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   irq_group_regs u_irq_group_regs (
      .clk (clk), .rst_n (rst_n), .evt_i (evt_i),
      .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .pend_o (pend_o)
   );

   // monitor: pops expected read data as responses appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R9: unexpected response, actual %h expected none", rsp_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rsp_rdata !== e) begin
               errors++;
               $display("FAIL %s: read actual %h expected %h", t, rsp_rdata, e);
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_read(input logic [3:0] a, input logic [31:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_write(input logic [3:0] a, input logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      chk("R9 no response to write", {31'b0, rsp_valid}, 32'h0);
   endtask

   task automatic pulse(input logic [31:0] v);
      evt_i = v;
      @(negedge clk);
      evt_i = '0;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 pending after reset", {31'b0, pend_o}, 32'h0);
      do_read(A_STAT, 32'h0, "R1 status");
      do_read(A_MASK, 32'h0, "R1 mask");
      do_read(A_IDENT, 32'h0, "R1 identity");
      do_read(A_ENAB, 32'h0, "R1 enable");
      // R5 whole-register replace
      do_write(A_MASK, 32'hFFFF_0000);
      do_read(A_MASK, 32'hFFFF_0000, "R5 mask readback");
      do_write(A_ENAB, 32'h0000_00F0);
      do_write(A_ENAB, 32'h0000_0000);
      do_read(A_ENAB, 32'h0, "R5 enable replaced");
      // R2 / R3 latch with mask
      pulse(32'h0001_0003);
      repeat (2) @(negedge clk);
      do_read(A_IDENT, 32'h0000_0003, "R2 R3 latched unmasked only");
      chk("R6 enable zero keeps pending low", {31'b0, pend_o}, 32'h0);
      do_write(A_MASK, 32'h0);
      do_read(A_IDENT, 32'h0000_0003, "R3 masked event lost");
      // R6 enable gating
      do_write(A_ENAB, 32'h0000_0002);
      chk("R6 pending after enable write", {31'b0, pend_o}, 32'h1);
      do_write(A_ENAB, 32'h0000_0004);
      chk("R6 pending off with disjoint enable", {31'b0, pend_o}, 32'h0);
      // R4 write-1-to-clear
      do_write(A_IDENT, 32'h0000_0001);
      do_read(A_IDENT, 32'h0000_0002, "R4 clear bit0");
      do_write(A_IDENT, 32'h0);
      do_read(A_IDENT, 32'h0000_0002, "R4 zero write keeps bits");
      // R7 event beats clear
      evt_i = 32'h0000_0002;
      do_write(A_IDENT, 32'h0000_0002);
      evt_i = '0;
      do_read(A_IDENT, 32'h0000_0002, "R7 event wins over clear");
      do_write(A_IDENT, 32'h0000_0002);
      do_read(A_IDENT, 32'h0, "R4 clear after collision");
      // R8 status read-only, raw inputs
      evt_i = 32'h0000_00A5;
      do_read(A_STAT, 32'h0000_00A5, "R8 status raw");
      do_write(A_STAT, 32'hFFFF_FFFF);
      evt_i = 32'h0000_005A;
      do_read(A_STAT, 32'h0000_005A, "R8 status follows input");
      evt_i = '0;
      do_read(A_MASK, 32'h0, "R8 status write leaves mask");
      do_read(A_ENAB, 32'h0000_0004, "R8 status write leaves enable");
      do_read(A_IDENT, 32'h0000_00FF, "R2 identity holds latched events");
      do_write(A_ENAB, 32'h0000_0080);
      chk("R6 pending on bit7", {31'b0, pend_o}, 32'h1);
      do_write(A_IDENT, 32'hFFFF_FFFF);
      chk("R6 pending after clear", {31'b0, pend_o}, 32'h0);
      // R10 misaligned and out-of-window accesses ignored
      req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h5; req_wdata = 32'h1234_5678;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      do_read(A_MASK, 32'h0, "R10 misaligned write ignored");
      req_valid = 1'b1; req_addr = 4'h6;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 misaligned read gives no response", {31'b0, rsp_valid}, 32'h0);
      do_write(A_MASK, 32'h1234_5678);
      do_read(A_MASK, 32'h1234_5678, "R10 mask at offset 4");
      do_read(A_ENAB, 32'h0000_0080, "R10 enable at offset C");
      repeat (3) @(negedge clk);
      chk("R9 all reads answered", exp_q.size(), 32'h0);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule